// File: doc/BRIEF.md
# SDRAM Single-Bank Write Sequencer

This block turns write requests from a client into a correctly timed command stream for one SDRAM bank. A request carries a row, a column, a full burst of data words and an auto-precharge flag. A second request kind asks for the open row to be closed. The block opens the row when the bank is closed. It reuses the row when it is already open, and closes and reopens it when a different row is asked for. It then issues the write and streams the burst onto the data bus, starting in the same cycle as the write command.

Every command waits for its own spacing rules. These are activate-to-write, activate-to-precharge, the write recovery after the last data beat, precharge-to-activate and the window a self-precharging write keeps the bank closed. The block issues each command at the first cycle in which all the rules that apply to it are met. While a self-precharge is in progress the bank is locked. Any request presented in that time is held back and flagged on a one-cycle error output.

Top module: `sdram_wr_bank_ctrl`

## Requirements
- R1: After reset the command bus carries NOP, the data enable and the error output are low, request ready is high, and the bank is closed, so the first write opens a row.
- R2: A write to a closed bank first issues ACT (command code 1) with the row on `addr_o`. The WRITE (code 2) follows exactly T_RCD cycles after the ACT.
- R3: A WRITE carries the column in `addr_o[COL_W-1:0]` and the auto-precharge flag in `addr_o[AP_BIT]` (bit 10 by default). Beat i is `req_burst[i*DW +: DW]`. Beat 0 is on `dq_o` in the WRITE cycle, and `dq_oe_o` stays high for BL consecutive cycles.
- R4: A write to the open row issues no ACT. A following write to that row is issued BL cycles after the previous WRITE, which keeps the data stream gapless.
- R5: PRE (code 3, `addr_o` all zero) is issued no earlier than BL-1+T_WR cycles after the last WRITE and T_RAS cycles after the ACT. It is issued at the first cycle both limits allow.
- R6: A write to a row other than the open one issues PRE and then ACT with the new row, exactly T_RP cycles after the PRE.
- R7: After a WRITE with the auto-precharge flag set, no PRE command is issued. The next ACT comes no earlier than BL+T_WR-1+T_RP cycles after that WRITE and no later than one cycle after that.
- R8: The bank is locked for BL+T_WR+T_RP-2 cycles starting with the self-precharging WRITE. During that time ready is low. For every cycle a request is presented, `err_o` is high in the following cycle. The held request is served afterwards.
- R9: `err_o` stays low when requests are only held back by ordinary sequencing outside the lock.
- R10: The command bus carries NOP (code 0) in every cycle in which no command is issued.
- R11: Elaboration rejects parameter sets where T_RCD+BL+T_WR-1 is not greater than T_RAS, or where BL is not 1, 2, 4 or 8.
- R12: A close request to a closed bank is accepted and issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_close | input | 1 | 1: close the open row, 0: write |
| req_row | input | ROW_W | Row to write |
| req_col | input | COL_W | Column start of the burst |
| req_autopre | input | 1 | Precharge the bank after this write |
| req_burst | input | BL*DW | Burst words, word 0 in the low bits |
| cmd_o | output | 2 | Command: 0 NOP, 1 ACT, 2 WRITE, 3 PRE |
| addr_o | output | ROW_W | Row on ACT; column and flag on WRITE |
| dq_o | output | DW | Write data |
| dq_oe_o | output | 1 | Write data valid |
| err_o | output | 1 | Request presented during lock |

## Verification
The write path is tried from a closed bank, on a hit to the open row, and on a miss to another row. These cases tell the ACT-to-WRITE spacing apart from the WRITE-to-WRITE spacing and from the recovery-then-precharge-then-activate chain. Back-to-back writes to one row check that the second burst follows the first with no gap and no repeated ACT. A write followed by a close measures write recovery on its own. A self-precharging write followed at once by a request to a new row checks the reopen window, the absence of an explicit PRE, and the exact number of error cycles. A close to a closed bank checks that the bus stays silent.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;

    // gap timer slots
    localparam int NTMR    = 5;
    localparam int TM_RCD  = 0;  // ACT -> WRITE
    localparam int TM_RAS  = 1;  // ACT -> PRE
    localparam int TM_WRP  = 2;  // WRITE -> PRE (burst + recovery)
    localparam int TM_ACTG = 3;  // PRE or self-precharge -> next ACT
    localparam int TM_BST  = 4;  // WRITE -> WRITE

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_wr_shift.sv
module sdram_wr_shift #(
    parameter int DW = 16,
    parameter int BL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [BL*DW-1:0] burst_i,
    output logic [DW-1:0]    dq_o,
    output logic             oe_o
);
    localparam int LW = $clog2(BL) + 1;

    typedef struct packed {
        logic [BL*DW-1:0] sh;
        logic [LW-1:0]    left;
        logic [DW-1:0]    dq;
        logic             oe;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.dq   = burst_i[DW-1:0];
            s_d.sh   = burst_i >> DW;
            s_d.left = LW'(BL - 1);
            s_d.oe   = 1'b1;
        end else if (s_q.left != '0) begin
            s_d.dq   = s_q.sh[DW-1:0];
            s_d.sh   = s_q.sh >> DW;
            s_d.left = s_q.left - 1'b1;
            s_d.oe   = 1'b1;
        end else begin
            s_d.dq = '0;
            s_d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dq_o = s_q.dq;
    assign oe_o = s_q.oe;
endmodule

// File: rtl/sdram_wr_bank_ctrl.sv
module sdram_wr_bank_ctrl
    import sdram_wr_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 8,
    parameter int AP_BIT = 10,
    parameter int DW     = 16,
    parameter int BL     = 4,
    parameter int T_RCD  = 2,
    parameter int T_WR   = 2,
    parameter int T_RP   = 2,
    parameter int T_RAS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_close,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             req_autopre,
    input  logic [BL*DW-1:0] req_burst,
    output logic [1:0]       cmd_o,
    output logic [ROW_W-1:0] addr_o,
    output logic [DW-1:0]    dq_o,
    output logic             dq_oe_o,
    output logic             err_o
);
    localparam int CW    = $clog2(BL + T_WR + T_RP + T_RAS + T_RCD + 2);
    localparam int L_RCD = T_RCD - 1;
    localparam int L_RAS = T_RAS - 1;
    localparam int L_WRP = BL + T_WR - 2;
    localparam int L_RP  = T_RP - 1;
    localparam int L_AP  = BL + T_WR - 1 + T_RP - 1;
    localparam int L_BST = BL - 1;

    // R11: configuration checks at elaboration
    if (!(T_RCD + BL + T_WR - 1 > T_RAS)) begin : g_bad_tras
        $error("write path shorter than minimum row active time");
    end
    if (BL != 1 && BL != 2 && BL != 4 && BL != 8) begin : g_bad_bl
        $error("burst length must be 1, 2, 4 or 8");
    end
    if (AP_BIT < COL_W || AP_BIT >= ROW_W) begin : g_bad_ap
        $error("auto-precharge bit overlaps column or exceeds address");
    end

    typedef struct packed {
        logic             bank_open;
        logic [ROW_W-1:0] open_row;
        logic             lock;
        logic             pend;
        logic             p_close;
        logic [ROW_W-1:0] p_row;
        logic [COL_W-1:0] p_col;
        logic             p_ap;
        logic [BL*DW-1:0] p_burst;
        cmd_e             cmd;
        logic [ROW_W-1:0] addr;
        logic             err;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic [NTMR-1:0]         tld;
    logic [NTMR-1:0][CW-1:0] tval;
    logic [NTMR-1:0]         tz;
    logic                    lockout;
    logic                    accept;

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        sdram_gap_timer #(.CW(CW)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (tld[i]),
            .val_i  (tval[i]),
            .zero_o (tz[i])
        );
    end

    assign lockout   = s_q.lock && !tz[TM_ACTG];
    assign req_ready = !s_q.pend && !lockout;
    assign accept    = req_valid && req_ready;

    always_comb begin
        s_d      = s_q;
        s_d.cmd  = CMD_NOP;
        s_d.addr = '0;
        s_d.err  = req_valid && lockout;
        tld      = '0;
        tval     = '0;

        if (tz[TM_ACTG]) begin
            s_d.lock = 1'b0;
        end

        if (accept) begin
            s_d.pend    = 1'b1;
            s_d.p_close = req_close;
            s_d.p_row   = req_row;
            s_d.p_col   = req_col;
            s_d.p_ap    = req_autopre;
            s_d.p_burst = req_burst;
        end else if (s_q.pend) begin
            if (!s_q.p_close) begin
                if (!s_q.bank_open) begin
                    if (tz[TM_ACTG]) begin
                        s_d.cmd          = CMD_ACT;
                        s_d.addr         = s_q.p_row;
                        s_d.bank_open    = 1'b1;
                        s_d.open_row     = s_q.p_row;
                        tld[TM_RCD]      = 1'b1;
                        tval[TM_RCD]     = CW'(L_RCD);
                        tld[TM_RAS]      = 1'b1;
                        tval[TM_RAS]     = CW'(L_RAS);
                    end
                end else if (s_q.open_row == s_q.p_row) begin
                    if (tz[TM_RCD] && tz[TM_BST]) begin
                        s_d.cmd                  = CMD_WR;
                        s_d.addr[COL_W-1:0]      = s_q.p_col;
                        s_d.addr[AP_BIT]         = s_q.p_ap;
                        s_d.pend                 = 1'b0;
                        tld[TM_BST]              = 1'b1;
                        tval[TM_BST]             = CW'(L_BST);
                        tld[TM_WRP]              = 1'b1;
                        tval[TM_WRP]             = CW'(L_WRP);
                        if (s_q.p_ap) begin
                            s_d.bank_open  = 1'b0;
                            s_d.lock       = 1'b1;
                            tld[TM_ACTG]   = 1'b1;
                            tval[TM_ACTG]  = CW'(L_AP);
                        end
                    end
                end else begin
                    if (tz[TM_WRP] && tz[TM_RAS]) begin
                        s_d.cmd       = CMD_PRE;
                        s_d.bank_open = 1'b0;
                        tld[TM_ACTG]  = 1'b1;
                        tval[TM_ACTG] = CW'(L_RP);
                    end
                end
            end else begin
                if (!s_q.bank_open) begin
                    s_d.pend = 1'b0;
                end else if (tz[TM_WRP] && tz[TM_RAS]) begin
                    s_d.cmd       = CMD_PRE;
                    s_d.bank_open = 1'b0;
                    s_d.pend      = 1'b0;
                    tld[TM_ACTG]  = 1'b1;
                    tval[TM_ACTG] = CW'(L_RP);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.cmd <= CMD_NOP;
        end else begin
            s_q <= s_d;
        end
    end

    sdram_wr_shift #(.DW(DW), .BL(BL)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (s_d.cmd == CMD_WR),
        .burst_i (s_q.p_burst),
        .dq_o    (dq_o),
        .oe_o    (dq_oe_o)
    );

    assign cmd_o  = s_q.cmd;
    assign addr_o = s_q.addr;
    assign err_o  = s_q.err;
endmodule

// File: rtl/sdram_wr_chk.sv
module sdram_wr_chk #(
    parameter int ROW_W  = 13,
    parameter int AP_BIT = 10,
    parameter int BL     = 4,
    parameter int T_RCD  = 2,
    parameter int T_WR   = 2,
    parameter int T_RP   = 2,
    parameter int T_RAS  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       cmd_o,
    input logic [ROW_W-1:0] addr_o,
    input logic             dq_oe_o,
    input logic             err_o
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [15:0] since_act, since_wr, since_pre, since_wra;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= SAT;
            since_wr  <= SAT;
            since_pre <= SAT;
            since_wra <= SAT;
        end else begin
            since_act <= (cmd_o == 2'd1) ? 16'd1 : (since_act == SAT ? SAT : since_act + 1'b1);
            since_wr  <= (cmd_o == 2'd2) ? 16'd1 : (since_wr  == SAT ? SAT : since_wr  + 1'b1);
            since_pre <= (cmd_o == 2'd3) ? 16'd1 : (since_pre == SAT ? SAT : since_pre + 1'b1);
            since_wra <= (cmd_o == 2'd2 && addr_o[AP_BIT]) ? 16'd1
                       : (since_wra == SAT ? SAT : since_wra + 1'b1);
        end
    end

    // R2
    act_to_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 2'd2 |-> since_act >= 16'(T_RCD));

    // R3
    wr_data_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 2'd2 |-> dq_oe_o);

    // R5
    wr_to_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 2'd3 |-> (since_wr >= 16'(BL - 1 + T_WR)) && (since_act >= 16'(T_RAS)));

    // R6
    pre_to_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 2'd1 |-> since_pre >= 16'(T_RP));

    // R7
    selfpre_to_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_o == 2'd1 |-> since_wra >= 16'(BL + T_WR - 1 + T_RP));

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(req_valid) && !$past(req_ready));
endmodule

bind sdram_wr_bank_ctrl sdram_wr_chk #(
    .ROW_W  (ROW_W),
    .AP_BIT (AP_BIT),
    .BL     (BL),
    .T_RCD  (T_RCD),
    .T_WR   (T_WR),
    .T_RP   (T_RP),
    .T_RAS  (T_RAS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_o     (cmd_o),
    .addr_o    (addr_o),
    .dq_oe_o   (dq_oe_o),
    .err_o     (err_o)
);

// File: tb/test_sdram_wr_bank_ctrl.sv
`timescale 1ns/1ps
module test_sdram_wr_bank_ctrl;
    localparam int ROW_W = 13, COL_W = 8, AP_BIT = 10, DW = 16, BL = 4;
    localparam int T_RCD = 2, T_WR = 2, T_RP = 2, T_RAS = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_close = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic             req_autopre = 1'b0;
    logic [BL*DW-1:0] req_burst = '0;
    logic [1:0]       cmd_o;
    logic [ROW_W-1:0] addr_o;
    logic [DW-1:0]    dq_o;
    logic             dq_oe_o;
    logic             err_o;

    always #2.5 clk = ~clk;

    sdram_wr_bank_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT), .DW(DW), .BL(BL),
        .T_RCD(T_RCD), .T_WR(T_WR), .T_RP(T_RP), .T_RAS(T_RAS)
    ) i_sdram_wr_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_close(req_close), .req_row(req_row), .req_col(req_col),
        .req_autopre(req_autopre), .req_burst(req_burst), .cmd_o(cmd_o),
        .addr_o(addr_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .err_o(err_o)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // monitor log
    int cyc = 0;
    int n_act, n_wr, n_pre, n_cmd, n_err, nbeat;
    int act_cyc, wr_cyc, prev_wr_cyc, pre_cyc, wra_cyc, first_beat;
    logic [ROW_W-1:0] act_addr, wr_addr, pre_addr, wra_addr;
    logic [DW-1:0] beats [16];

    task automatic clear_log();
        n_act = 0; n_wr = 0; n_pre = 0; n_cmd = 0; n_err = 0; nbeat = 0;
        act_cyc = -1; wr_cyc = -1; prev_wr_cyc = -1; pre_cyc = -1;
        wra_cyc = -1; first_beat = -1;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (cmd_o != 2'd0) n_cmd++;
            if (cmd_o == 2'd1) begin n_act++; act_cyc = cyc; act_addr = addr_o; end
            if (cmd_o == 2'd2) begin
                n_wr++; prev_wr_cyc = wr_cyc; wr_cyc = cyc; wr_addr = addr_o;
                if (addr_o[AP_BIT]) begin wra_cyc = cyc; wra_addr = addr_o; end
            end
            if (cmd_o == 2'd3) begin n_pre++; pre_cyc = cyc; pre_addr = addr_o; end
            if (dq_oe_o) begin
                if (nbeat == 0) first_beat = cyc;
                if (nbeat < 16) beats[nbeat] = dq_o;
                nbeat++;
            end
            if (err_o) n_err++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic send(input bit close, input logic [ROW_W-1:0] row,
                        input logic [COL_W-1:0] col, input bit ap,
                        input logic [BL*DW-1:0] burst);
        @(negedge clk);
        req_valid = 1'b1; req_close = close; req_row = row;
        req_col = col; req_autopre = ap; req_burst = burst;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        rst_n = 1'b0;
        settle(3);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 cmd", cmd_o, 0);
        chk_eq("R1 dq_oe", dq_oe_o, 0);
        chk_eq("R1 err", err_o, 0);
        chk_eq("R1 ready", req_ready, 1);
        clear_log();
    endtask

    // R2 R3 R9 R10 R1 (first write opens a row)
    task automatic t_idle_write();
        logic [63:0] b = 64'h4444_3333_2222_1111;
        clear_log();
        send(1'b0, 13'h0ABC, 8'h15, 1'b0, b);
        settle(20);
        chk_eq("R1 first write opens row (ACT count)", n_act, 1);
        chk_eq("R2 ACT row", act_addr, 13'h0ABC);
        chk_eq("R2 ACT to WRITE gap", wr_cyc - act_cyc, T_RCD);
        chk_eq("R3 column", wr_addr[COL_W-1:0], 8'h15);
        chk_eq("R3 autopre bit low", wr_addr[AP_BIT], 0);
        chk_eq("R3 first beat in WRITE cycle", first_beat, wr_cyc);
        chk_eq("R3 beat count", nbeat, BL);
        for (int i = 0; i < BL; i++) chk_eq("R3 beat data", beats[i], b[i*DW +: DW]);
        chk_eq("R9 no error", n_err, 0);
        clear_log();
        settle(10);
        chk_eq("R10 NOP when idle", n_cmd, 0);
    endtask

    // R5 R4
    task automatic t_close();
        clear_log();
        send(1'b0, 13'h0ABC, 8'h20, 1'b0, 64'h0D0C_0B0A_0908_0706);
        send(1'b1, '0, '0, 1'b0, '0);
        settle(20);
        chk_eq("R4 no ACT on hit", n_act, 0);
        chk_eq("R5 PRE count", n_pre, 1);
        chk_eq("R5 WRITE to PRE gap", pre_cyc - wr_cyc, BL - 1 + T_WR);
        chk_eq("R5 PRE addr zero", pre_addr, 0);
        chk_eq("R9 no error", n_err, 0);
    endtask

    // R12
    task automatic t_close_closed();
        clear_log();
        send(1'b1, '0, '0, 1'b0, '0);
        settle(10);
        chk_eq("R12 no command", n_cmd, 0);
        chk_eq("R12 ready", req_ready, 1);
    endtask

    // R4 R3
    task automatic t_row_hit();
        logic [63:0] b2 = 64'hDDDD_CCCC_BBBB_AAAA;
        clear_log();
        send(1'b0, 13'h0055, 8'h00, 1'b0, 64'h8888_7777_6666_5555);
        send(1'b0, 13'h0055, 8'h40, 1'b0, b2);
        settle(20);
        chk_eq("R4 single ACT", n_act, 1);
        chk_eq("R4 WRITE to WRITE gap", wr_cyc - prev_wr_cyc, BL);
        chk_eq("R3 gapless beats", nbeat, 2 * BL);
        for (int i = 0; i < BL; i++) chk_eq("R3 second burst data", beats[BL + i], b2[i*DW +: DW]);
    endtask

    // R6 R5
    task automatic t_row_miss();
        clear_log();
        send(1'b0, 13'h0055, 8'h01, 1'b0, 64'h1);
        send(1'b0, 13'h01F0, 8'h02, 1'b0, 64'h2);
        settle(25);
        chk_eq("R6 PRE count", n_pre, 1);
        chk_eq("R5 recovery before PRE", pre_cyc - prev_wr_cyc, BL - 1 + T_WR);
        chk_eq("R6 PRE to ACT gap", act_cyc - pre_cyc, T_RP);
        chk_eq("R6 new row", act_addr, 13'h01F0);
        chk_eq("R2 ACT to WRITE gap", wr_cyc - act_cyc, T_RCD);
    endtask

    // R7 R8
    task automatic t_autopre();
        int gap;
        clear_log();
        send(1'b0, 13'h01F0, 8'h33, 1'b1, 64'h0F0F_0E0E_0D0D_0C0C);
        send(1'b0, 13'h00AA, 8'h00, 1'b0, 64'h9);
        settle(30);
        gap = act_cyc - wra_cyc;
        chk_eq("R7 autopre bit high", wra_addr[AP_BIT], 1);
        chk_eq("R7 no explicit PRE", n_pre, 0);
        chk(gap >= BL + T_WR - 1 + T_RP && gap <= BL + T_WR + T_RP, "R7 reopen window",
            gap, BL + T_WR - 1 + T_RP);
        chk_eq("R8 error cycles", n_err, BL + T_WR + T_RP - 2);
        chk_eq("R8 held request served (ACT row)", act_addr, 13'h00AA);
        chk_eq("R8 held request served (WRITE count)", n_wr, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        clear_log();
        t_reset();
        t_idle_write();
        t_close();
        t_close_closed();
        t_row_hit();
        t_row_miss();
        t_autopre();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule